// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block sequences an 8-bit successive-approximation conversion for an external comparator and DAC, with a choice of eight analog inputs. Software writes a channel number and a clock-select bit and pulses start. The block then steers the input multiplexer, holds a sample window open, and searches the code space one bit at a time, most significant bit first. It drives each trial code to the DAC and reads the comparator's one-bit decision back. When the frame ends it loads the result register, drops busy and pulses a completion interrupt.

Every conversion takes exactly 26 periods of the conversion clock, and the first 6 periods are the sample window. The conversion clock is either the system clock or half of it. The block has no data stream: it takes one request and gives one result per frame, so all pins are plain control and status levels or pulses, with no valid/ready handshake and no back-pressure. The comparator input is expected to follow the trial code combinationally.

Top module: `sar_seq`

## Requirements
- R1: At the end of a conversion, result equals the largest code C for which the comparator reports cmp_keep=1 (analog ≥ trial) on every trial that C passes. For an ideal comparator this is the analog code itself.
- R2: A conversion holds busy high for exactly 26·D system clocks, where D=1 when ctl_half=0 and D=2 when ctl_half=1.
- R3: sample_en is high for exactly the first 6·D system clocks of each conversion and low at all other times.
- R4: ctl_half is captured at the accepted start, and changing it during a conversion does not alter the frame length.
- R5: Trial bits are resolved MSB first, one bit per two conversion clocks. Each bit is set and then kept if cmp_keep=1 or cleared if cmp_keep=0. dac_code is 00h during sampling.
- R6: Analog code FFh converts to FFh and analog code 00h converts to 00h, so the result saturates at the ends of the range.
- R7: A ctl_start pulse that arrives while busy is high is ignored. The running frame keeps its length, and no second frame follows it.
- R8: In the system clock where busy first reads low after a conversion, done_irq is high and result holds the new value. done_irq is high for that one clock only, and result changes at no other time.
- R9: mux_sel equals the channel captured at the accepted start and stays stable for the whole conversion, even if ctl_chan changes.
- R10: After reset, busy, sample_en, done_irq, result and dac_code are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_chan | input | 3 | Requested input channel |
| ctl_half | input | 1 | 0: conversion clock = system clock; 1: half rate |
| ctl_start | input | 1 | Start request, accepted only when not busy |
| cmp_keep | input | 1 | Comparator decision: 1 when analog ≥ trial code |
| dac_code | output | 8 | Trial code to the DAC |
| mux_sel | output | 3 | Channel select to the analog multiplexer |
| sample_en | output | 1 | Sample-and-hold enable |
| result | output | 8 | Last conversion result |
| busy | output | 1 | Conversion in progress |
| done_irq | output | 1 | One-clock completion pulse |

## Verification
The bench builds the block with its default parameters: an 8-bit code, 8 channels, a 26-clock frame and a 6-clock sample window. With these values every one of the 256 codes can be swept at both clock-select settings, with the channel rotating through all eight inputs, and seeded random conversions are added on top. During each frame the bench rewrites the channel, flips the clock-select bit and issues an extra start pulse. This exposes the captured channel and clock setting and the rejection of starts while busy to the same per-frame checks of result, frame length and sample-window length.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int CODE_W   = 8;
  localparam int CHAN_N   = 8;
  localparam int CHAN_W   = $clog2(CHAN_N);
  localparam int FRAME_N  = 26;
  localparam int SAMPLE_N = 6;
  localparam int CNT_W    = $clog2(FRAME_N);
endpackage

// File: rtl/sar_tick.sv
module sar_tick (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic half,
  output logic tick
);
  logic ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ph <= 1'b0;
    else if (!run) ph <= 1'b0;
    else           ph <= ~ph;
  end

  assign tick = run & (~half | ph);

  // R2: at half rate no two consecutive ticks
  p_half_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && half && run) |=> !tick);
endmodule

// File: rtl/sar_frame.sv
module sar_frame
  import sar_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             tick,
  output logic             busy,
  output logic [CNT_W-1:0] cnt,
  output logic             last,
  output logic             sample_en
);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(FRAME_N - 1);
  localparam logic [CNT_W-1:0] SAMP_C = CNT_W'(SAMPLE_N);

  assign last      = busy & tick & (cnt == LAST_C);
  assign sample_en = busy & (cnt < SAMP_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (go) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy && tick) begin
      if (cnt == LAST_C) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R3: sampling only inside a frame
  p_sample_in_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |-> busy);
  // R2: counter never passes the last slot
  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt <= LAST_C));
endmodule

// File: rtl/sar_bits.sv
module sar_bits
  import sar_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              tick,
  input  logic              busy,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              keep,
  input  logic              load,
  output logic [CODE_W-1:0] code,
  output logic [CODE_W-1:0] result,
  output logic              done
);
  genvar gi;
  generate
    for (gi = 0; gi < CODE_W; gi++) begin : g_bit
      localparam logic [CNT_W-1:0] SET_AT = CNT_W'(SAMPLE_N + 2*(CODE_W-1-gi));
      localparam logic [CNT_W-1:0] DEC_AT = CNT_W'(SAMPLE_N + 2*(CODE_W-1-gi) + 1);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       code[gi] <= 1'b0;
        else if (clear)                   code[gi] <= 1'b0;
        else if (busy && tick && cnt == SET_AT) code[gi] <= 1'b1;
        else if (busy && tick && cnt == DEC_AT && !keep) code[gi] <= 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= load;
      if (load) result <= code;
    end
  end

  // R8: result moves only together with the completion pulse
  p_result_with_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> done);
  // R8: completion pulse lasts one clock
  p_irq_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CHAN_W-1:0] ctl_chan,
  input  logic              ctl_half,
  input  logic              ctl_start,
  input  logic              cmp_keep,
  output logic [CODE_W-1:0] dac_code,
  output logic [CHAN_W-1:0] mux_sel,
  output logic              sample_en,
  output logic [CODE_W-1:0] result,
  output logic              busy,
  output logic              done_irq
);
  logic             go, tick, last, half_q;
  logic [CNT_W-1:0] cnt;

  assign go = ctl_start & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mux_sel <= '0;
      half_q  <= 1'b0;
    end else if (go) begin
      mux_sel <= ctl_chan;
      half_q  <= ctl_half;
    end
  end

  sar_tick u_tick (
    .clk(clk), .rst_n(rst_n), .run(busy), .half(half_q), .tick(tick)
  );

  sar_frame u_frame (
    .clk(clk), .rst_n(rst_n), .go(go), .tick(tick),
    .busy(busy), .cnt(cnt), .last(last), .sample_en(sample_en)
  );

  sar_bits u_bits (
    .clk(clk), .rst_n(rst_n), .clear(go), .tick(tick), .busy(busy),
    .cnt(cnt), .keep(cmp_keep), .load(last),
    .code(dac_code), .result(result), .done(done_irq)
  );

  // R9: channel held through the frame
  p_chan_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mux_sel));
  // R5: no trial code while sampling
  p_dac_idle_sample_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |-> (dac_code == '0));
  // R8: end of frame raises the interrupt
  p_fall_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_irq);
endmodule

// File: tb/sar_seq_bench.sv
module sar_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] ctl_chan = '0;
  logic       ctl_half = 1'b0;
  logic       ctl_start = 1'b0;
  logic       cmp_keep;
  logic [7:0] dac_code, result;
  logic [2:0] mux_sel;
  logic       sample_en, busy, done_irq;
  logic [7:0] analog [8];

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  assign cmp_keep = analog[mux_sel] >= dac_code;

  sar_seq u_sar_seq (
    .clk(clk), .rst_n(rst_n), .ctl_chan(ctl_chan), .ctl_half(ctl_half),
    .ctl_start(ctl_start), .cmp_keep(cmp_keep), .dac_code(dac_code),
    .mux_sel(mux_sel), .sample_en(sample_en), .result(result),
    .busy(busy), .done_irq(done_irq)
  );

  function automatic int frame_len(input logic h);
    return h ? 52 : 26;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic convert(input logic [7:0] code, input logic [2:0] ch, input logic h);
    int n = 0;
    int s = 0;
    for (int k = 0; k < 8; k++) analog[k] = ~code;
    analog[ch] = code;
    @(negedge clk);
    ctl_chan = ch; ctl_half = h; ctl_start = 1'b1;
    @(negedge clk);
    ctl_start = 1'b0;
    while (busy && n < 200) begin
      n++;
      if (sample_en) s++;
      if (mux_sel != ch) chk(0, "R9 mux_sel", mux_sel, ch);
      if (n == 3) begin ctl_chan = ch ^ 3'd1; ctl_half = ~h; end
      if (n == 10) ctl_start = 1'b1;   // R7 start while busy
      if (n == 11) ctl_start = 1'b0;
      @(negedge clk);
    end
    chk(n == frame_len(h), "R2 R4 frame length", n, frame_len(h));
    chk(s == (h ? 12 : 6), "R3 sample window", s, h ? 12 : 6);
    chk(done_irq == 1'b1, "R8 irq at busy fall", done_irq, 1);
    chk(result == code, "R1 R5 R6 result", result, code);
    @(negedge clk);
    chk(!done_irq && !busy, "R7 R8 no extra frame or pulse", {busy, done_irq}, 0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd1234));
    for (int k = 0; k < 8; k++) analog[k] = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done_irq && !sample_en, "R10 reset flags", {busy, done_irq, sample_en}, 0);
    chk(result == 8'h00 && dac_code == 8'h00, "R10 reset data", result, 0);
    rst_n = 1'b1;
    @(negedge clk);
    convert(8'hFF, 3'd7, 1'b0);   // R6 top of range
    convert(8'h00, 3'd0, 1'b0);   // R6 bottom of range
    convert(8'hFF, 3'd3, 1'b1);
    convert(8'h00, 3'd4, 1'b1);
    convert(8'h80, 3'd5, 1'b1);
    convert(8'h7F, 3'd6, 1'b0);
    for (int h = 0; h < 2; h++)
      for (int c = 0; c < 256; c++)
        convert(8'(c), 3'(c + h), h[0]);
    for (int r = 0; r < 200; r++)
      convert(8'($urandom), 3'($urandom), 1'($urandom));
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule